// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is one 8-bit pulse-width channel. A free-running counter steps once per prescaled tick while the channel is on. Two working registers, period and duty, shape the waveform. Each has a write buffer in front of it, so software can stage new values without breaking the cycle in progress. The staged values move into the working registers at a period boundary, or at once when the counter is written. The channel drives a single PWM pin, and it exposes the live count as a plain read port.

Two shapes are offered. In left-aligned mode the counter ramps up and wraps. In center-aligned mode it counts up and back down in a triangle, which gives a symmetric pulse. The polarity bit selects whether the active phase is high or low.

Writing the counter is the way to restart the channel cleanly. Switching the channel off only pauses it. All write strobes and the tick are single-cycle, qualified by the clock. None of them is back-pressured and each is acted on in the cycle it is seen.

Top module: `pwm_slice`

## Requirements
- R1: During and after reset the count reads 0, the output is 0, and the period and duty registers (working and staged) hold 0.
- R2: The count moves only on a clock edge where `tick` is 1 (or where the counter is written). Reading `cnt_rd` has no side effect.
- R3: A pulse on `cnt_wr` forces the following on the next edge. The count becomes 0 and the direction becomes up. Both working registers take their staged values, including a value staged in the same cycle. The output takes the level of `pol`.
- R4: While `chan_en` is 0 the count holds, apart from R3 and R5. When `chan_en` returns to 1, counting resumes from the held value.
- R5: While `chan_en` is 0 and the working period is 0, the first edge with `tick`=1 clears the count to 0.
- R6: In left-aligned mode (`center_sel`=0) with working period P>0, each enabled tick adds 1 to the count. A tick at count P-1 (or above) wraps the count to 0 and copies both staged values into the working registers.
- R7: After every enabled tick, the output equals `pol` when the new count is below the working duty, and equals the inverse of `pol` otherwise. This means the output changes state at the duty match.
- R8: In center-aligned mode (`center_sel`=1) with P>0, the count climbs 0,1,…,P and then falls P-1,…,0. The tick that brings it down to 0 copies the staged values into the working registers.
- R9: A write to `per_wdata`/`duty_wdata` (via `per_wr`/`duty_wr`) while enabled changes only the staged value. The waveform keeps the old value until the next reload. While disabled, the write also updates the working register at once.
- R10: With the channel enabled and a working period of 0, every tick leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled count enable, one cycle wide |
| chan_en | input | 1 | Channel run (1) or pause (0) |
| pol | input | 1 | Active-phase level of the output |
| center_sel | input | 1 | 0 left-aligned, 1 center-aligned |
| cnt_wr | input | 1 | Counter write strobe (data ignored) |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | 8 | Period write value |
| duty_wr | input | 1 | Duty write strobe |
| duty_wdata | input | 8 | Duty write value |
| cnt_rd | output | 8 | Current count |
| pwm_out | output | 1 | PWM waveform |

## Verification
Directed runs cover several waveforms:
- A left-aligned ramp with period 5 and duty 2 separates the wrap point from the duty edge.
- A period rewrite in the middle of a period shows whether the new value leaks in before the boundary.
- A pause with ticks still running, a zero period, and counter writes under both polarities each isolate one restart path.
- A center-aligned triangle with period 4 tells a turn at P apart from a turn at P-1.

A long seeded random mix then toggles enable, mode, polarity and all strobes against a cycle model in the bench.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} cnt_dir_e;
  localparam int REG_PER  = 0;
  localparam int REG_DUTY = 1;
  localparam int NUM_REGS = 2;
endpackage

// File: rtl/pwm_slice_dbuf.sv
module pwm_slice_dbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         chan_en,
  input  logic         load,
  output logic [W-1:0] act_q,
  output logic [W-1:0] act_nxt
);
  logic [W-1:0] stage_q;
  logic [W-1:0] stage_nxt;

  // staged value seen by a load in the same cycle as the write
  assign stage_nxt = wr_en ? wr_data : stage_q;
  assign act_nxt   = (load || (wr_en && !chan_en)) ? stage_nxt : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      stage_q <= stage_nxt;
      act_q   <= act_nxt;
    end
  end
endmodule

// File: rtl/pwm_slice_ctr.sv
module pwm_slice_ctr
  import pwm_slice_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         chan_en,
  input  logic         center_sel,
  input  logic         cnt_wr,
  input  logic [W-1:0] per_act,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         reload,
  output logic         step
);
  localparam int WX = W + 1;
  localparam logic [W-1:0]  ONE  = W'(1);
  localparam logic [WX-1:0] ONEX = WX'(1);

  cnt_dir_e     dir_q, dir_nxt;
  logic [WX-1:0] cnt_inc_x;
  logic          per_zero;

  assign step      = chan_en && tick && !cnt_wr;
  assign per_zero  = (per_act == '0);
  assign cnt_inc_x = {1'b0, cnt_q} + ONEX;

  always_comb begin
    cnt_nxt = cnt_q;
    dir_nxt = dir_q;
    reload  = 1'b0;
    if (cnt_wr) begin
      cnt_nxt = '0;
      dir_nxt = DIR_UP;
      reload  = 1'b1;
    end else if (!chan_en && tick && per_zero) begin
      cnt_nxt = '0;
      dir_nxt = DIR_UP;
    end else if (step) begin
      if (per_zero) begin
        cnt_nxt = '0;
        dir_nxt = DIR_UP;
        reload  = 1'b1;
      end else if (!center_sel) begin
        dir_nxt = DIR_UP;
        if (cnt_inc_x >= {1'b0, per_act}) begin
          cnt_nxt = '0;
          reload  = 1'b1;
        end else begin
          cnt_nxt = cnt_q + ONE;
        end
      end else begin
        if (dir_q == DIR_UP) begin
          if (cnt_q >= per_act) begin
            dir_nxt = DIR_DOWN;
            cnt_nxt = cnt_q - ONE;
          end else begin
            cnt_nxt = cnt_q + ONE;
          end
        end else if (cnt_q == '0) begin
          dir_nxt = DIR_UP;
          cnt_nxt = ONE;
        end else begin
          cnt_nxt = cnt_q - ONE;
        end
        reload = (cnt_nxt == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_nxt;
      dir_q <= dir_nxt;
    end
  end
endmodule

// File: rtl/pwm_slice_wave.sv
module pwm_slice_wave #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         cnt_wr,
  input  logic         pol,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] duty_nxt,
  output logic         pwm_q
);
  logic active;

  assign active = (cnt_nxt < duty_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else if (cnt_wr) begin
      pwm_q <= pol;
    end else if (step) begin
      pwm_q <= active ? pol : !pol;
    end
  end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_slice_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         chan_en,
  input  logic         pol,
  input  logic         center_sel,
  input  logic         cnt_wr,
  input  logic         per_wr,
  input  logic [W-1:0] per_wdata,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_wdata,
  output logic [W-1:0] cnt_rd,
  output logic         pwm_out
);
  logic [NUM_REGS-1:0]        wr_v;
  logic [NUM_REGS-1:0][W-1:0] wd_v;
  logic [NUM_REGS-1:0][W-1:0] act_v;
  logic [NUM_REGS-1:0][W-1:0] actn_v;
  logic [W-1:0] per_act;
  logic [W-1:0] cnt_q, cnt_nxt;
  logic         reload, step;

  assign wr_v[REG_PER]  = per_wr;
  assign wr_v[REG_DUTY] = duty_wr;
  assign wd_v[REG_PER]  = per_wdata;
  assign wd_v[REG_DUTY] = duty_wdata;
  assign per_act        = act_v[REG_PER];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    pwm_slice_dbuf #(.W(W)) u_dbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_v[g]),
      .wr_data (wd_v[g]),
      .chan_en (chan_en),
      .load    (reload),
      .act_q   (act_v[g]),
      .act_nxt (actn_v[g])
    );
  end

  pwm_slice_ctr #(.W(W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .chan_en    (chan_en),
    .center_sel (center_sel),
    .cnt_wr     (cnt_wr),
    .per_act    (per_act),
    .cnt_q      (cnt_q),
    .cnt_nxt    (cnt_nxt),
    .reload     (reload),
    .step       (step)
  );

  pwm_slice_wave #(.W(W)) u_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .cnt_wr   (cnt_wr),
    .pol      (pol),
    .cnt_nxt  (cnt_nxt),
    .duty_nxt (actn_v[REG_DUTY]),
    .pwm_q    (pwm_out)
  );

  assign cnt_rd = cnt_q;
endmodule

// File: rtl/pwm_slice_chk.sv
module pwm_slice_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         chan_en,
  input logic         pol,
  input logic         center_sel,
  input logic         cnt_wr,
  input logic [W-1:0] cnt_rd,
  input logic         pwm_out,
  input logic [W-1:0] per_act
);
  AST_CNT_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_rd == '0)); // R3
  AST_CNT_WR_POL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (pwm_out == $past(pol))); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt_rd)); // R2
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !cnt_wr && per_act != '0) |=> $stable(cnt_rd)); // R4
  AST_PAUSE_ZERO_PER: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && tick && per_act == '0) |=> (cnt_rd == '0)); // R5
  AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!center_sel && chan_en && tick && !cnt_wr && per_act != '0 && cnt_rd < per_act)
    |=> (cnt_rd < $past(per_act))); // R6
  AST_CENTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (center_sel && chan_en && tick && !cnt_wr && per_act != '0 && cnt_rd <= per_act)
    |=> (cnt_rd == W'($past(cnt_rd) + 1'b1) || cnt_rd == W'($past(cnt_rd) - 1'b1))); // R8
  AST_ZERO_PER_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && tick && per_act == '0) |=> (cnt_rd == '0)); // R10
endmodule

bind pwm_slice pwm_slice_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .chan_en    (chan_en),
  .pol        (pol),
  .center_sel (center_sel),
  .cnt_wr     (cnt_wr),
  .cnt_rd     (cnt_rd),
  .pwm_out    (pwm_out),
  .per_act    (per_act)
);

// File: tb/tb_pwm_slice.sv
module tb_pwm_slice;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, chan_en = 1'b0, pol = 1'b0, center_sel = 1'b0;
  logic       cnt_wr = 1'b0, per_wr = 1'b0, duty_wr = 1'b0;
  logic [7:0] per_wdata = '0, duty_wdata = '0;
  logic [7:0] cnt_rd;
  logic       pwm_out;

  int n_checks = 0;
  int n_err = 0;

  // bench reference state
  logic [7:0] m_cnt = '0, m_pb = '0, m_pa = '0, m_db = '0, m_da = '0;
  logic       m_up = 1'b1, m_out = 1'b0;
  logic [7:0] n_cnt, n_pb, n_pa, n_db, n_da;
  logic       n_up, n_out;

  always #5 clk = ~clk;

  pwm_slice dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .chan_en(chan_en), .pol(pol),
    .center_sel(center_sel), .cnt_wr(cnt_wr), .per_wr(per_wr),
    .per_wdata(per_wdata), .duty_wr(duty_wr), .duty_wdata(duty_wdata),
    .cnt_rd(cnt_rd), .pwm_out(pwm_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_calc();
    logic stp, rel;
    stp = chan_en && tick && !cnt_wr;
    rel = 1'b0;
    n_pb = per_wr ? per_wdata : m_pb;
    n_db = duty_wr ? duty_wdata : m_db;
    n_cnt = m_cnt;
    n_up = m_up;
    if (cnt_wr) begin
      n_cnt = 0; n_up = 1'b1; rel = 1'b1;
    end else if (!chan_en && tick && m_pa == 0) begin
      n_cnt = 0; n_up = 1'b1;
    end else if (stp) begin
      if (m_pa == 0) begin
        n_cnt = 0; n_up = 1'b1; rel = 1'b1;
      end else if (!center_sel) begin
        n_up = 1'b1;
        if (int'(m_cnt) + 1 >= int'(m_pa)) begin n_cnt = 0; rel = 1'b1; end
        else n_cnt = m_cnt + 8'd1;
      end else begin
        if (m_up) begin
          if (m_cnt >= m_pa) begin n_up = 1'b0; n_cnt = m_cnt - 8'd1; end
          else n_cnt = m_cnt + 8'd1;
        end else if (m_cnt == 0) begin
          n_up = 1'b1; n_cnt = 8'd1;
        end else n_cnt = m_cnt - 8'd1;
        rel = (n_cnt == 0);
      end
    end
    n_pa = (rel || (per_wr && !chan_en)) ? n_pb : m_pa;
    n_da = (rel || (duty_wr && !chan_en)) ? n_db : m_da;
    n_out = m_out;
    if (cnt_wr) n_out = pol;
    else if (stp) n_out = (n_cnt < n_da) ? pol : !pol;
  endtask

  // one clock: predict, clock, compare, return at the falling edge
  task automatic cyc(input string tag);
    model_calc();
    @(posedge clk);
    #1;
    m_cnt = n_cnt; m_up = n_up; m_pb = n_pb; m_pa = n_pa;
    m_db = n_db; m_da = n_da; m_out = n_out;
    chk({tag, " count"}, int'(cnt_rd), int'(m_cnt));
    chk({tag, " output"}, int'(pwm_out), int'(m_out));
    @(negedge clk);
  endtask

  task automatic clr_strobes();
    cnt_wr = 1'b0; per_wr = 1'b0; duty_wr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset count", int'(cnt_rd), 0);
    chk("R1 reset output", int'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: writes while paused reach working registers; R3: clean start
    chan_en = 1'b0; pol = 1'b1; center_sel = 1'b0;
    per_wr = 1'b1; per_wdata = 8'd5; cyc("R9 paused period");
    clr_strobes();
    duty_wr = 1'b1; duty_wdata = 8'd2; cyc("R9 paused duty");
    clr_strobes();
    cnt_wr = 1'b1; cyc("R3 start");
    clr_strobes();
    chk("R3 cleared", int'(cnt_rd), 0);
    chk("R3 polarity level", int'(pwm_out), 1);

    // R6/R7: left ramp, period 5 duty 2
    chan_en = 1'b1; tick = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      cyc("R6 left");
      chk("R6 ramp count", int'(cnt_rd), k % 5);
      chk("R7 duty level", int'(pwm_out), ((k % 5) < 2) ? 1 : 0);
    end

    // R2: no tick, no movement
    tick = 1'b0;
    for (int k = 0; k < 3; k++) begin
      cyc("R2 idle");
      chk("R2 count held", int'(cnt_rd), 0);
    end

    // R9: period staged mid-period takes effect at the boundary
    cnt_wr = 1'b1; cyc("R3 restart"); clr_strobes();
    tick = 1'b1;
    begin
      int exp_seq [8] = '{1, 2, 3, 4, 0, 1, 2, 0};
      for (int k = 0; k < 8; k++) begin
        if (k == 1) begin per_wr = 1'b1; per_wdata = 8'd3; end
        cyc("R9 staged");
        clr_strobes();
        chk("R9 staged period", int'(cnt_rd), exp_seq[k]);
      end
    end

    // R4: pause with ticks running, then resume
    cyc("R4 pre");
    chan_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      cyc("R4 paused");
      chk("R4 held", int'(cnt_rd), 1);
    end
    chan_en = 1'b1;
    cyc("R4 resume");
    chk("R4 resumed", int'(cnt_rd), 2);

    // R5: zero period while paused clears on next tick
    chan_en = 1'b0; tick = 1'b0;
    per_wr = 1'b1; per_wdata = 8'd0; cyc("R5 write"); clr_strobes();
    chk("R5 before tick", int'(cnt_rd), 2);
    tick = 1'b1; cyc("R5 tick");
    chk("R5 cleared", int'(cnt_rd), 0);

    // R10: enabled with zero period stays at zero
    chan_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cyc("R10 zero period");
      chk("R10 count", int'(cnt_rd), 0);
    end

    // R3: counter write mid-period under both polarities
    per_wr = 1'b1; per_wdata = 8'd6; chan_en = 1'b0; cyc("R3 setup"); clr_strobes();
    chan_en = 1'b1;
    repeat (3) cyc("R3 run");
    pol = 1'b0; cnt_wr = 1'b1; cyc("R3 pol0"); clr_strobes();
    chk("R3 pol0 count", int'(cnt_rd), 0);
    chk("R3 pol0 level", int'(pwm_out), 0);
    repeat (3) cyc("R3 run");
    pol = 1'b1; cnt_wr = 1'b1; cyc("R3 pol1"); clr_strobes();
    chk("R3 pol1 level", int'(pwm_out), 1);

    // R8: center triangle period 4 duty 2
    chan_en = 1'b0; tick = 1'b0; center_sel = 1'b1;
    per_wr = 1'b1; per_wdata = 8'd4; duty_wr = 1'b1; duty_wdata = 8'd2;
    cnt_wr = 1'b1; cyc("R8 setup"); clr_strobes();
    chan_en = 1'b1; tick = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      int pos, c;
      pos = k % 8;
      c = (pos <= 4) ? pos : 8 - pos;
      cyc("R8 center");
      chk("R8 triangle count", int'(cnt_rd), c);
      chk("R7 center level", int'(pwm_out), (c < 2) ? 1 : 0);
    end

    // seeded random mix against the bench model
    for (int k = 0; k < 4000; k++) begin
      tick = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 99) < 4) chan_en = !chan_en;
      if ($urandom_range(0, 199) < 2) pol = !pol;
      if ($urandom_range(0, 199) < 2) center_sel = !center_sel;
      cnt_wr = ($urandom_range(0, 99) < 2);
      per_wr = ($urandom_range(0, 99) < 4);
      per_wdata = 8'($urandom_range(0, 12));
      duty_wr = ($urandom_range(0, 99) < 4);
      duty_wdata = 8'($urandom_range(0, 13));
      cyc("R6 R7 R8 R9 random");
    end
    clr_strobes();

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule